// File: doc/BRIEF.md
# Phased Sweeping Reset Sequencer

This block drives the command stream for phased display on a mirror array that is split into reset blocks. Each block is written, reset, cleared and reset again in a cascade from the top block to the bottom one. While one block's mirrors settle after a reset, other blocks are loading. The visible image is a window of two blocks that moves down the array. Each block stays on screen for about the time taken to load two blocks.

A neighbouring row loader and a block reset controller carry out the commands. The sequencer presents one command at a time and holds it until the executing unit returns a one-cycle done. Before it raises any command, it checks that the target block is not inside its mirror settle time. If the block is still settling, the sequencer waits. When the bottom block has finished its clear, a frame-done pulse is produced. If start is still high at that moment, the next frame begins at block 0 at once.

Top module: `phase_sweep_seq`

## Requirements
- R1: While rst is high, and in the cycle after it, cmd_valid and frame_done are 0.
- R2: One frame issues exactly 4*NUM_BLOCKS commands. For each block index k, rising from 0: load k, then reset k. Then, if k >= LAG (LAG = 2): clear k-LAG, then reset k-LAG. After block NUM_BLOCKS-1 the remaining blocks NUM_BLOCKS-LAG to NUM_BLOCKS-1 each get a clear and then a reset, in rising order. The cmd_op encoding is 0 = load, 1 = reset and 2 = clear.
- R3: While cmd_valid is high and cmd_done is low, cmd_valid, cmd_op and cmd_block hold in the next cycle. In the cycle after cmd_done is high, cmd_valid is low.
- R4: A command is raised only if blk_settling[target] was low in the cycle before cmd_valid rises. While that bit stays high, cmd_valid stays low.
- R5: frame_done is high for exactly one cycle, the cycle after the done of the last command of the frame (the reset that follows the clear of block NUM_BLOCKS-1).
- R6: If start is high in the cycle in which the last done arrives, cmd_valid rises for load 0 one cycle after frame_done. If start is low, the block goes idle and issues nothing.
- R7: start has no effect while a frame is in progress.
- R8: From idle, a start seen in cycle t raises cmd_valid in cycle t+2 when block 0 is not settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame when idle or at the end of a frame |
| blk_settling | input | NUM_BLOCKS | One bit per block, high while that block is inside its settle time |
| cmd_done | input | 1 | One-cycle completion of the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_op | output | 2 | 0 load, 1 reset, 2 clear |
| cmd_block | output | $clog2(NUM_BLOCKS) | Target block of the command |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The checks assume three things about the inputs. First, the executing units pulse cmd_done only while a command is presented, and for one cycle only. Second, blk_settling changes only between clock edges. Third, reset is held for at least two cycles. The bench responder answers each command after zero to two extra cycles and drops done right away. It starts a settle window only for the blocks it has just reset, so real settle stalls happen inside a frame. A separate forced settle mask holds block 0 busy to exercise the stall at frame start.

// File: rtl/phase_sweep_pkg.sv
package phase_sweep_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_RESET = 2'd1,
    OP_CLEAR = 2'd2
  } sweep_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/sweep_step_gen.sv
module sweep_step_gen
  import phase_sweep_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int LAG        = 2,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int KW = $clog2(NUM_BLOCKS + LAG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  output sweep_op_e     op,
  output logic [BW-1:0] blk,
  output logic          last
);
  logic [KW-1:0] k_q, k_n, lagged;
  logic [1:0]    ph_q, ph_n;

  // phase 0/1 act on block k, phase 2/3 act on block k-LAG
  always_comb begin
    lagged = k_q - KW'(LAG);
    blk    = ph_q[1] ? lagged[BW-1:0] : k_q[BW-1:0];
    case (ph_q)
      2'd0:    op = OP_LOAD;
      2'd2:    op = OP_CLEAR;
      default: op = OP_RESET;
    endcase
    last = (k_q == KW'(NUM_BLOCKS + LAG - 1)) && (ph_q == 2'd3);
  end

  always_comb begin
    k_n  = k_q;
    ph_n = ph_q;
    case (ph_q)
      2'd0: ph_n = 2'd1;
      2'd1: begin
        if (k_q >= KW'(LAG)) begin
          ph_n = 2'd2;
        end else begin
          k_n  = k_q + KW'(1);
          ph_n = 2'd0;
        end
      end
      2'd2: ph_n = 2'd3;
      default: begin
        k_n  = k_q + KW'(1);
        ph_n = (k_q < KW'(NUM_BLOCKS - 1)) ? 2'd0 : 2'd2;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      k_q  <= '0;
      ph_q <= 2'd0;
    end else if (advance) begin
      k_q  <= k_n;
      ph_q <= ph_n;
    end
  end
endmodule

// File: rtl/sweep_cmd_reg.sv
module sweep_cmd_reg
  import phase_sweep_pkg::*;
#(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          drop,
  input  sweep_op_e     op_in,
  input  logic [BW-1:0] blk_in,
  output logic          valid,
  output logic [1:0]    op,
  output logic [BW-1:0] blk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      op    <= 2'd0;
      blk   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      op    <= op_in;
      blk   <= blk_in;
    end else if (drop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_sweep_seq.sv
module phase_sweep_seq
  import phase_sweep_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int LAG        = 2,
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_BLOCKS-1:0] blk_settling,
  input  logic                  cmd_done,
  output logic                  cmd_valid,
  output logic [1:0]            cmd_op,
  output logic [BW-1:0]         cmd_block,
  output logic                  frame_done
);
  sweep_state_e  state_q, state_n;
  sweep_op_e     step_op;
  logic [BW-1:0] step_blk;
  logic          step_last, step_adv, step_restart;
  logic          issue, drop, fd_n;

  sweep_step_gen #(.NUM_BLOCKS(NUM_BLOCKS), .LAG(LAG)) step_i (
    .clk(clk), .rst(rst), .restart(step_restart), .advance(step_adv),
    .op(step_op), .blk(step_blk), .last(step_last)
  );

  sweep_cmd_reg #(.BW(BW)) cmd_i (
    .clk(clk), .rst(rst), .load(issue), .drop(drop),
    .op_in(step_op), .blk_in(step_blk),
    .valid(cmd_valid), .op(cmd_op), .blk(cmd_block)
  );

  always_comb begin
    state_n      = state_q;
    issue        = 1'b0;
    drop         = 1'b0;
    step_adv     = 1'b0;
    step_restart = 1'b0;
    fd_n         = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          step_restart = 1'b1;
          state_n      = SQ_ISSUE;
        end
      end
      SQ_ISSUE: begin
        if (!blk_settling[step_blk]) begin
          issue   = 1'b1;
          state_n = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (cmd_done) begin
          drop = 1'b1;
          if (step_last) begin
            fd_n         = 1'b1;
            step_restart = 1'b1;
            state_n      = start ? SQ_ISSUE : SQ_IDLE;
          end else begin
            step_adv = 1'b1;
            state_n  = SQ_ISSUE;
          end
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      frame_done <= 1'b0;
    end else begin
      state_q    <= state_n;
      frame_done <= fd_n;
    end
  end
endmodule

// File: rtl/phase_sweep_chk.sv
module phase_sweep_chk #(
  parameter int NUM_BLOCKS = 16,
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_BLOCKS-1:0] blk_settling,
  input logic                  cmd_done,
  input logic                  cmd_valid,
  input logic [1:0]            cmd_op,
  input logic [BW-1:0]         cmd_block,
  input logic                  frame_done
);
  logic [NUM_BLOCKS-1:0] settle_q;
  always_ff @(posedge clk) settle_q <= blk_settling;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !frame_done));

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_block)));

  assert_cmd_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_done) |=> !cmd_valid);

  assert_settle_gate_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> !settle_q[cmd_block]);

  assert_op_legal_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_op != 2'd3));

  assert_fd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_fd_idle_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !cmd_valid);
endmodule

bind phase_sweep_seq phase_sweep_chk #(.NUM_BLOCKS(NUM_BLOCKS)) chk_i (
  .clk(clk), .rst(rst), .blk_settling(blk_settling), .cmd_done(cmd_done),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_block(cmd_block),
  .frame_done(frame_done)
);

// File: tb/phase_sweep_seq_tb.sv
module phase_sweep_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB      = 16;
  localparam int LAGN    = 2;
  localparam int BW      = $clog2(NB);
  localparam int SEQ_LEN = 4 * NB;
  localparam int SETTLE  = 25;

  logic clk = 1'b0;
  logic rst, start, cmd_done;
  logic [NB-1:0] settle_r, force_mask, blk_settling;
  logic cmd_valid, frame_done;
  logic [1:0] cmd_op;
  logic [BW-1:0] cmd_block;

  assign blk_settling = settle_r | force_mask;
  always #(CLK_PERIOD/2) clk = ~clk;

  phase_sweep_seq #(.NUM_BLOCKS(NB), .LAG(LAGN)) dut_i (
    .clk(clk), .rst(rst), .start(start), .blk_settling(blk_settling),
    .cmd_done(cmd_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_block(cmd_block), .frame_done(frame_done)
  );

  int checks = 0, failures = 0;
  int seq_op[SEQ_LEN];
  int seq_blk[SEQ_LEN];
  int m_state, m_idx, e_valid, e_op, e_blk, e_fd;
  int fd_count = 0, ncmd = 0, wcnt = 0, dly = 0, rec_op = 0, rec_blk = 0;
  int cnt[NB];
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R2 expected command list
  initial begin
    int n = 0;
    for (int k = 0; k < NB; k++) begin
      seq_op[n] = 0; seq_blk[n] = k; n++;
      seq_op[n] = 1; seq_blk[n] = k; n++;
      if (k >= LAGN) begin
        seq_op[n] = 2; seq_blk[n] = k - LAGN; n++;
        seq_op[n] = 1; seq_blk[n] = k - LAGN; n++;
      end
    end
    for (int j = NB - LAGN; j < NB; j++) begin
      seq_op[n] = 2; seq_blk[n] = j; n++;
      seq_op[n] = 1; seq_blk[n] = j; n++;
    end
  end

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_idx = 0; e_valid = 0; e_op = 0; e_blk = 0; e_fd = 0;
    end else begin
      e_fd = 0;
      case (m_state)
        0: if (start) begin m_idx = 0; m_state = 1; end
        1: if (!blk_settling[seq_blk[m_idx]]) begin
             e_valid = 1; e_op = seq_op[m_idx]; e_blk = seq_blk[m_idx]; m_state = 2;
           end
        default: if (cmd_done) begin
             e_valid = 0;
             if (m_idx == SEQ_LEN - 1) begin
               e_fd = 1; m_idx = 0; m_state = start ? 1 : 0;
             end else begin
               m_idx++; m_state = 1;
             end
           end
      endcase
    end
  end

  // compare, responder and settle model on the falling edge
  initial begin
    cmd_done = 0; settle_r = '0;
    for (int b = 0; b < NB; b++) cnt[b] = 0;
  end
  always @(negedge clk) begin
    chk("R3 cmd_valid", int'(cmd_valid), e_valid);
    if (e_valid != 0) begin
      chk("R2 cmd_op", int'(cmd_op), e_op);
      chk("R2 cmd_block", int'(cmd_block), e_blk);
    end
    chk("R5 frame_done", int'(frame_done), e_fd);
    if (frame_done) fd_count++;
    for (int b = 0; b < NB; b++) if (cnt[b] > 0) cnt[b]--;
    if (cmd_done) begin
      cmd_done = 0;
      if (rec_op == 1) cnt[rec_blk] = SETTLE;
    end else if (cmd_valid) begin
      if (wcnt >= dly) begin
        cmd_done = 1; rec_op = cmd_op; rec_blk = cmd_block;
        wcnt = 0; ncmd++; dly = ncmd % 3;
      end else wcnt++;
    end
    for (int b = 0; b < NB; b++) settle_r[b] = (cnt[b] > 0);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; start = 0; force_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset cmd_valid", int'(cmd_valid), 0);
    chk("R1 reset frame_done", int'(frame_done), 0);
    rst = 0;
    @(negedge clk);
    // R8 start latency from idle
    start = 1;
    @(negedge clk); start = 0;
    chk("R8 no cmd one cycle after start", int'(cmd_valid), 0);
    @(negedge clk);
    chk("R8 cmd two cycles after start", int'(cmd_valid), 1);
    // R7 start pulse mid frame
    repeat (30) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait (fd_count == 1);
    repeat (10) @(negedge clk);
    chk("R6 idle after frame with start low", int'(cmd_valid), 0);
    chk("R7 one frame only", fd_count, 1);
    chk("R2 commands per frame", ncmd, SEQ_LEN);
    // R4 stall on settling block 0
    force_mask = 1;
    start = 1; @(negedge clk); start = 0;
    repeat (12) begin
      @(negedge clk);
      chk("R4 stalled while settling", int'(cmd_valid), 0);
    end
    force_mask = '0;
    @(negedge clk);
    chk("R4 issue after settle ends", int'(cmd_valid), 1);
    wait (fd_count == 2);
    @(negedge clk);
    // R6 back-to-back frames
    start = 1;
    wait (fd_count == 3);
    @(negedge clk);
    chk("R6 next frame immediately", int'(cmd_valid), 1);
    start = 0;
    wait (fd_count == 4);
    repeat (10) @(negedge clk);
    chk("R6 idle after last frame", int'(cmd_valid), 0);
    chk("R5 frame count", fd_count, 4);
    chk("R2 total commands", ncmd, 4 * SEQ_LEN);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule